// File: doc/BRIEF.md
# Chip Erase Sequencer with Verify Retry

This controller sits on the host side of a flash command bus and carries out a full-chip erase under external control. After a start pulse it reads the whole array. If any byte is not already zero, it programs every byte to zero first, so that all cells enter the erase from the same state. It then issues erase pulses and walks the array with erase-verify reads until every byte reads back erased, or until an upper limit of pulses has been used.

There is one pulse counter for the whole walk. When a verify fails, the controller issues one more pulse and checks the same address again. It does not revisit addresses that have already passed. All waits are counted in clock cycles and set by parameters. Each bus access takes one cycle. Read data is sampled in the same cycle as the read strobe.

Top module: `erase_seq`

## Requirements
- R1: After start, one 00H write is followed by a read of each address in ascending order. If any byte read is not 00H, every address is programmed before the first erase pulse. Programming an address means a 40H write, then a write of 00H to that address, then exactly PROG_CYC idle cycles. If every byte reads 00H, no 40H write is issued.
- R2: An erase pulse is two 20H writes in consecutive cycles. The next bus write follows the second 20H write by exactly ERASE_CYC+1 cycles.
- R3: An erase verify is an A0H write that carries the address under test. It is followed by exactly VFY_CYC idle cycles, and then by a read of that same address.
- R4: A byte counts as erased only when it reads FFH. The first verify after the first pulse checks address 0. A passing verify moves to the next address with no further pulse.
- R5: A failing verify triggers another erase pulse. Verification then resumes at the failing address, not at address 0.
- R6: A pass at the highest address ends the run with done_o high and fail_o low. The number of pulses used equals the most that any byte needed.
- R7: If a verify fails after MAX_PULSES pulses have been issued, the run ends with fail_o high, done_o low and exactly MAX_PULSES pulses used. A byte that needs exactly MAX_PULSES pulses still passes.
- R8: Reset drives busy_o, done_o, fail_o and both bus strobes low. busy_o rises in the cycle after start_i is sampled, stays high through every bus access of the run, and falls when done_o or fail_o rises. done_o and fail_o hold until the next start, which clears them.
- R9: A bus write and a bus read never occur in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Starts a run when the block is idle |
| busy_o | output | 1 | High while a run is in progress |
| done_o | output | 1 | Last run erased the whole array |
| fail_o | output | 1 | Last run ran out of pulses |
| bus_wr_o | output | 1 | Write strobe, one cycle per access |
| bus_rd_o | output | 1 | Read strobe, data sampled the same cycle |
| bus_addr_o | output | ADDR_W | Bus address |
| bus_wdata_o | output | 8 | Command or program data |
| bus_rdata_i | input | 8 | Read data from the flash |

## Verification
The bench uses a behavioural flash in which each byte needs its own number of pulses before it reads FFH. With it the bench can produce a slow byte in the middle of the array, a slow byte at the last address, and a byte that needs exactly the pulse limit or more.

- A design that restarts the walk at address 0 after a retry shows extra verify reads of addresses that have already passed.
- A design with an off-by-one limit check either fails a run that needs exactly MAX_PULSES pulses, or issues one pulse too many.
- Skipping the zero pre-program is caught by a non-zero byte still present at the first pulse.
- Programming a clean array is caught by a non-zero count of program writes.
- Wrong wait lengths are caught by exact gaps measured between bus writes and between each verify write and its read.

// File: rtl/erase_seq_pkg.sv
package erase_seq_pkg;

  localparam logic [7:0] CMD_READ  = 8'h00;
  localparam logic [7:0] CMD_PROG  = 8'h40;
  localparam logic [7:0] CMD_ERASE = 8'h20;
  localparam logic [7:0] CMD_EVFY  = 8'hA0;
  localparam logic [7:0] BYTE_ZERO = 8'h00;
  localparam logic [7:0] BYTE_ERSD = 8'hFF;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SCAN_CMD,
    ST_SCAN_RD,
    ST_PP_SETUP,
    ST_PP_DATA,
    ST_PP_WAIT,
    ST_ER_CMD1,
    ST_ER_CMD2,
    ST_ER_WAIT,
    ST_EV_CMD,
    ST_EV_WAIT,
    ST_EV_RD
  } seq_state_e;

endpackage

// File: rtl/erase_seq_timer.sv
module erase_seq_timer #(
  parameter int unsigned TMR_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [TMR_W-1:0] len_i,
  output logic             expired_o
);

  logic [TMR_W-1:0] cnt_q;

  // load with len-1 so a wait state lasts exactly len cycles
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= len_i - TMR_W'(1);
    else if (cnt_q != '0)    cnt_q <= cnt_q - TMR_W'(1);
  end

  assign expired_o = (cnt_q == '0);

  a_r2_timer_counts_down: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - TMR_W'(1)));

  a_r3_timer_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == $past(len_i) - TMR_W'(1)));

endmodule

// File: rtl/erase_seq_addr.sv
module erase_seq_addr #(
  parameter int unsigned ADDR_W = 17
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              inc_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              last_o
);

  logic [ADDR_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     addr_q <= '0;
    else if (clr_i)  addr_q <= '0;
    else if (inc_i)  addr_q <= addr_q + ADDR_W'(1);
  end

  assign addr_o = addr_q;
  assign last_o = &addr_q;

  a_r4_addr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !clr_i) |=> (addr_q == $past(addr_q) + ADDR_W'(1)));

  a_r4_addr_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (addr_q == '0));

endmodule

// File: rtl/erase_seq_pulses.sv
module erase_seq_pulses #(
  parameter int unsigned MAX_PULSES = 3000,
  parameter int unsigned PCNT_W     = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic inc_i,
  output logic at_max_o
);

  logic [PCNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (inc_i)  cnt_q <= cnt_q + PCNT_W'(1);
  end

  assign at_max_o = (cnt_q == PCNT_W'(MAX_PULSES));

  a_r7_pulse_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= PCNT_W'(MAX_PULSES));

  a_r7_no_pulse_past_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    at_max_o |-> !inc_i);

endmodule

// File: rtl/erase_seq.sv
module erase_seq
  import erase_seq_pkg::*;
#(
  parameter int unsigned ADDR_W     = 17,
  parameter int unsigned ERASE_CYC  = 2500000,
  parameter int unsigned VFY_CYC    = 1500,
  parameter int unsigned PROG_CYC   = 6250,
  parameter int unsigned MAX_PULSES = 3000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              fail_o,
  output logic              bus_wr_o,
  output logic              bus_rd_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [7:0]        bus_wdata_o,
  input  logic [7:0]        bus_rdata_i
);

  localparam int unsigned MAX_EV   = (ERASE_CYC > VFY_CYC) ? ERASE_CYC : VFY_CYC;
  localparam int unsigned MAX_WAIT = (MAX_EV > PROG_CYC) ? MAX_EV : PROG_CYC;
  localparam int unsigned TMR_W    = $clog2(MAX_WAIT + 1);
  localparam int unsigned PCNT_W   = $clog2(MAX_PULSES + 1);

  seq_state_e st_q, st_d;
  logic dirty_q, dirty_d, done_q, done_d, fail_q, fail_d;
  logic addr_clr, addr_inc, addr_last;
  logic pc_clr, pc_inc, pc_at_max;
  logic tmr_load, tmr_exp;
  logic [TMR_W-1:0] tmr_len;
  logic [ADDR_W-1:0] addr;
  logic rd_zero, rd_erased;

  assign rd_zero   = (bus_rdata_i == BYTE_ZERO);
  assign rd_erased = (bus_rdata_i == BYTE_ERSD);

  erase_seq_addr #(.ADDR_W(ADDR_W)) u_addr (
    .clk_i (clk_i), .rst_ni (rst_ni), .clr_i (addr_clr), .inc_i (addr_inc),
    .addr_o (addr), .last_o (addr_last)
  );

  erase_seq_pulses #(.MAX_PULSES(MAX_PULSES), .PCNT_W(PCNT_W)) u_pulses (
    .clk_i (clk_i), .rst_ni (rst_ni), .clr_i (pc_clr), .inc_i (pc_inc),
    .at_max_o (pc_at_max)
  );

  erase_seq_timer #(.TMR_W(TMR_W)) u_timer (
    .clk_i (clk_i), .rst_ni (rst_ni), .load_i (tmr_load), .len_i (tmr_len),
    .expired_o (tmr_exp)
  );

  always_comb begin
    st_d        = st_q;
    dirty_d     = dirty_q;
    done_d      = done_q;
    fail_d      = fail_q;
    addr_clr    = 1'b0;
    addr_inc    = 1'b0;
    pc_clr      = 1'b0;
    pc_inc      = 1'b0;
    tmr_load    = 1'b0;
    tmr_len     = '0;
    bus_wr_o    = 1'b0;
    bus_rd_o    = 1'b0;
    bus_wdata_o = BYTE_ZERO;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          st_d     = ST_SCAN_CMD;
          addr_clr = 1'b1;
          pc_clr   = 1'b1;
          dirty_d  = 1'b0;
          done_d   = 1'b0;
          fail_d   = 1'b0;
        end
      end
      ST_SCAN_CMD: begin
        bus_wr_o    = 1'b1;
        bus_wdata_o = CMD_READ;
        st_d        = ST_SCAN_RD;
      end
      ST_SCAN_RD: begin
        bus_rd_o = 1'b1;
        dirty_d  = dirty_q | ~rd_zero;
        if (addr_last) begin
          addr_clr = 1'b1;
          st_d     = (dirty_q || !rd_zero) ? ST_PP_SETUP : ST_ER_CMD1;
        end else begin
          addr_inc = 1'b1;
        end
      end
      ST_PP_SETUP: begin
        bus_wr_o    = 1'b1;
        bus_wdata_o = CMD_PROG;
        st_d        = ST_PP_DATA;
      end
      ST_PP_DATA: begin
        bus_wr_o    = 1'b1;
        bus_wdata_o = BYTE_ZERO;
        tmr_load    = 1'b1;
        tmr_len     = TMR_W'(PROG_CYC);
        st_d        = ST_PP_WAIT;
      end
      ST_PP_WAIT: begin
        if (tmr_exp) begin
          if (addr_last) begin
            addr_clr = 1'b1;
            st_d     = ST_ER_CMD1;
          end else begin
            addr_inc = 1'b1;
            st_d     = ST_PP_SETUP;
          end
        end
      end
      ST_ER_CMD1: begin
        bus_wr_o    = 1'b1;
        bus_wdata_o = CMD_ERASE;
        st_d        = ST_ER_CMD2;
      end
      ST_ER_CMD2: begin
        bus_wr_o    = 1'b1;
        bus_wdata_o = CMD_ERASE;
        pc_inc      = 1'b1;
        tmr_load    = 1'b1;
        tmr_len     = TMR_W'(ERASE_CYC);
        st_d        = ST_ER_WAIT;
      end
      ST_ER_WAIT: begin
        if (tmr_exp) st_d = ST_EV_CMD;
      end
      ST_EV_CMD: begin
        bus_wr_o    = 1'b1;
        bus_wdata_o = CMD_EVFY;
        tmr_load    = 1'b1;
        tmr_len     = TMR_W'(VFY_CYC);
        st_d        = ST_EV_WAIT;
      end
      ST_EV_WAIT: begin
        if (tmr_exp) st_d = ST_EV_RD;
      end
      ST_EV_RD: begin
        bus_rd_o = 1'b1;
        if (rd_erased) begin
          if (addr_last) begin
            done_d = 1'b1;
            st_d   = ST_IDLE;
          end else begin
            addr_inc = 1'b1;
            st_d     = ST_EV_CMD;
          end
        end else if (pc_at_max) begin
          fail_d = 1'b1;
          st_d   = ST_IDLE;
        end else begin
          st_d = ST_ER_CMD1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      dirty_q <= 1'b0;
      done_q  <= 1'b0;
      fail_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      dirty_q <= dirty_d;
      done_q  <= done_d;
      fail_q  <= fail_d;
    end
  end

  assign busy_o     = (st_q != ST_IDLE);
  assign done_o     = done_q;
  assign fail_o     = fail_q;
  assign bus_addr_o = addr;

  a_r9_no_wr_rd_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bus_wr_o && bus_rd_o));

  a_r8_busy_excludes_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !(done_o || fail_o));

  a_r6_done_fail_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && fail_o));

  a_r5_retry_same_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_EV_RD && !rd_erased && !pc_at_max) |=> (st_q == ST_ER_CMD1 && $stable(bus_addr_o)));

  a_r7_fail_at_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fail_o) |-> pc_at_max);

  a_r2_second_erase_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_ER_CMD1) |=> (bus_wr_o && bus_wdata_o == CMD_ERASE));

endmodule

// File: tb/erase_seq_tb_top.sv
module erase_seq_tb_top;

  localparam int AW    = 3;
  localparam int DEPTH = 1 << AW;
  localparam int E_CYC = 5;
  localparam int V_CYC = 2;
  localparam int P_CYC = 3;
  localparam int MAXP  = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic busy, done, fail, bus_wr, bus_rd;
  logic [AW-1:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;

  always #2 clk = ~clk;

  erase_seq #(
    .ADDR_W(AW), .ERASE_CYC(E_CYC), .VFY_CYC(V_CYC), .PROG_CYC(P_CYC), .MAX_PULSES(MAXP)
  ) dut_i (
    .clk_i (clk), .rst_ni (rst_n), .start_i (start), .busy_o (busy), .done_o (done),
    .fail_o (fail), .bus_wr_o (bus_wr), .bus_rd_o (bus_rd), .bus_addr_o (bus_addr),
    .bus_wdata_o (bus_wdata), .bus_rdata_i (bus_rdata)
  );

  // behavioural flash: byte a turns FFH once pulses >= need[a]
  logic [7:0] mem [DEPTH];
  int need [DEPTH];
  assign bus_rdata = mem[bus_addr];

  int vectors = 0, miscmp = 0;
  int cyc = 0, pulses = 0, nprog = 0, n40 = 0, nv = 0;
  int e_gap = 0, e_vfy = 0, e_zero = 0, e_busy = 0, e_ovl = 0, e_prog = 0;
  int exp_wr = -1, vf_t = 0, vf_a = 0;
  bit prev20 = 0, pend_prog = 0, vf_pend = 0;
  int vlog [64];
  int vpul [64];

  always @(posedge clk) begin
    bit pulsed;
    pulsed = 0;
    cyc++;
    if (bus_wr && bus_rd) e_ovl++;
    if ((bus_wr || bus_rd) && !busy) e_busy++;
    if (bus_wr) begin
      if (exp_wr >= 0 && cyc != exp_wr) e_gap++;
      exp_wr = -1;
      if (pend_prog) begin
        pend_prog = 0;
        if (bus_wdata != 8'h00 || pulses != 0) e_prog++;
        mem[bus_addr] = mem[bus_addr] & bus_wdata;
        nprog++;
        exp_wr = cyc + P_CYC + 1;
      end else if (bus_wdata == 8'h40) begin
        pend_prog = 1; n40++;
      end else if (bus_wdata == 8'h20 && prev20) begin
        pulsed = 1;
        pulses++;
        if (pulses == 1)
          for (int a = 0; a < DEPTH; a++) if (mem[a] != 8'h00) e_zero++;
        for (int a = 0; a < DEPTH; a++) if (pulses >= need[a]) mem[a] = 8'hFF;
        exp_wr = cyc + E_CYC + 1;
      end else if (bus_wdata == 8'hA0) begin
        vf_pend = 1; vf_t = cyc; vf_a = int'(bus_addr);
      end
    end
    if (bus_rd && vf_pend) begin
      if (cyc != vf_t + V_CYC + 1 || int'(bus_addr) != vf_a) e_vfy++;
      vf_pend = 0;
      if (nv < 64) begin vlog[nv] = int'(bus_addr); vpul[nv] = pulses; end
      nv++;
    end
    prev20 = bus_wr && bus_wdata == 8'h20 && !pulsed;
  end

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscmp++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_model();
    pulses = 0; nprog = 0; n40 = 0; nv = 0;
    e_gap = 0; e_vfy = 0; e_zero = 0; e_busy = 0; e_ovl = 0; e_prog = 0;
    exp_wr = -1; prev20 = 0; pend_prog = 0; vf_pend = 0;
  endtask

  task automatic run_seq();
    int guard;
    clear_model();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk("R8 busy after start", int'(busy), 1);
    chk("R8 done cleared by start", int'(done), 0);
    chk("R8 fail cleared by start", int'(fail), 0);
    guard = 0;
    while (busy && guard < 20000) begin @(negedge clk); guard++; end
    chk("R8 run terminates", int'(busy), 0);
  endtask

  task automatic common_checks();
    chk("R2 erase wait gap", e_gap, 0);
    chk("R3 verify timing and address", e_vfy, 0);
    chk("R8 bus only while busy", e_busy, 0);
    chk("R9 no write/read overlap", e_ovl, 0);
  endtask

  task automatic t_reset();
    chk("R8 reset busy", int'(busy), 0);
    chk("R8 reset done", int'(done), 0);
    chk("R8 reset fail", int'(fail), 0);
    chk("R8 reset strobes", int'(bus_wr | bus_rd), 0);
  endtask

  task automatic t_clean_array();
    for (int a = 0; a < DEPTH; a++) begin mem[a] = 8'h00; need[a] = 1; end
    run_seq();
    chk("R1 no program on clean array", n40, 0);
    chk("R6 done", int'(done), 1);
    chk("R6 not fail", int'(fail), 0);
    chk("R6 pulses used", pulses, 1);
    chk("R4 one verify per address", nv, DEPTH);
    chk("R4 first verify at address 0", vlog[0], 0);
    chk("R4 last verify at top", vlog[DEPTH-1], DEPTH-1);
    common_checks();
  endtask

  task automatic t_dirty_array();
    for (int a = 0; a < DEPTH; a++) begin mem[a] = 8'(a * 37 + 1); need[a] = 1; end
    mem[0] = 8'h00;
    run_seq();
    chk("R1 every byte programmed", nprog, DEPTH);
    chk("R1 program data/order", e_prog, 0);
    chk("R1 all zero at first pulse", e_zero, 0);
    chk("R6 done after preprogram", int'(done), 1);
    chk("R6 pulses used", pulses, 1);
    common_checks();
  endtask

  task automatic t_resume_mid();
    for (int a = 0; a < DEPTH; a++) begin mem[a] = 8'h00; need[a] = 1; end
    need[3] = 3;
    run_seq();
    chk("R6 done", int'(done), 1);
    chk("R6 pulses = slowest byte", pulses, 3);
    chk("R5 verify count", nv, DEPTH + 2);
    chk("R5 retry addr after pulse 2", vlog[4], 3);
    chk("R5 pulse index at retry", vpul[4], 2);
    chk("R5 retry addr after pulse 3", vlog[5], 3);
    chk("R4 advance after pass", vlog[6], 4);
    common_checks();
  endtask

  task automatic t_limit_exact();
    for (int a = 0; a < DEPTH; a++) begin mem[a] = 8'h00; need[a] = 1; end
    need[DEPTH-1] = MAXP;
    run_seq();
    chk("R7 exact limit passes", int'(done), 1);
    chk("R7 exact limit not fail", int'(fail), 0);
    chk("R7 pulses at exact limit", pulses, MAXP);
    chk("R6 final verify at top", vlog[nv-1], DEPTH-1);
    common_checks();
  endtask

  task automatic t_limit_exceeded();
    for (int a = 0; a < DEPTH; a++) begin mem[a] = 8'h00; need[a] = 1; end
    need[5] = 10;
    run_seq();
    chk("R7 fail flagged", int'(fail), 1);
    chk("R7 done low on fail", int'(done), 0);
    chk("R7 pulses capped", pulses, MAXP);
    chk("R7 verify count", nv, 6 + MAXP - 1);
    chk("R5 last verify at stuck addr", vlog[nv-1], 5);
    repeat (3) @(negedge clk);
    chk("R8 fail held", int'(fail), 1);
    common_checks();
  endtask

  initial begin
    for (int a = 0; a < DEPTH; a++) begin mem[a] = 8'h00; need[a] = 1; end
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_clean_array();
    t_dirty_array();
    t_resume_mid();
    t_limit_exact();
    t_limit_exceeded();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
    $finish;
  end

  initial begin
    #800000;
    miscmp++;
    $display("FAIL R8 watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
    $finish;
  end

endmodule